// File: doc/BRIEF.md
# MSR Access Intercept Bitmap Lookup

This block decides whether a guest read or write of a model-specific register has to leave the guest. A request carries a 32-bit register index, a read/write flag and the base address of a 4 KiB intercept bitmap. The block sorts the index into one of three regions. The low region runs from 0x00000000 to 0x00001FFF. The high region runs from 0xC0000000 to 0xC0001FFF. Every other index falls in the third region.

For an index in the low or high region, the block works out the byte that holds its flag. It fetches that single byte over a simple valid/ready request channel and a valid-qualified response channel. It then takes the flag bit selected by the index's three lowest bits. Any index outside both regions exits at once, with no memory access.

The decision appears on `exit_req` together with a one-cycle `done` pulse. It stays on `exit_req` until the next decision replaces it. While a lookup is in flight, `busy` is high and new requests are dropped.

Top module: `msr_intercept_lookup`

## Requirements
- R1: For a read of an index from 0x00000000 to 0x00001FFF, the fetched address is base + (index >> 3).
- R2: The high region is a true range test: only indices from 0xC0000000 to 0xC0001FFF qualify. A read of one fetches base + 1024 + ((index - 0xC0000000) >> 3).
- R3: A write adds 2048 to the byte offset that a read of the same index would use, in both regions.
- R4: The decision is bit index[2:0] of the returned byte, with bit 0 the least significant. A 1 means exit (`exit_req` = 1) and a 0 means no exit.
- R5: Any index above 0xC0001FFF yields `exit_req` = 1. `mem_req_valid` never rises for it, and `done` comes in the cycle after the request is accepted.
- R6: Any index from 0x00002000 to 0xBFFFFFFF behaves as in R5 (forced exit, no fetch). This includes 0xA0000000, which shares its top bit with the high range.
- R7: `mem_req_valid` rises in the cycle after acceptance. It stays high with a stable address until a cycle with `mem_req_ready` high. A response is taken only on the first `mem_rsp_valid` after that handshake; a response strobe seen before the handshake is ignored.
- R8: `done` is high for exactly one cycle per accepted request. `exit_req` changes only in the cycle `done` is high and holds its value otherwise.
- R9: `busy` is high from the cycle after acceptance up to and including the `done` cycle. Requests presented while `busy` is high are dropped.
- R10: After reset, `busy`, `done`, `exit_req` and `mem_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe, taken while idle |
| req_index | input | 32 | Register index of the guest access |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| bitmap_base | input | ADDR_W | Base address of the 4 KiB bitmap, 4 KiB aligned |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle pulse when a decision is ready |
| exit_req | output | 1 | Decision: 1 = the access must exit |
| mem_req_valid | output | 1 | Byte-read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address to read |
| mem_rsp_valid | input | 1 | Response byte valid |
| mem_rsp_data | input | 8 | Response byte |

## Verification
When a request is accepted at a clock edge, `busy` rises in the next cycle. `mem_req_valid` also rises then for an in-range index, while `done` rises then for a forced-exit index. After the response edge, `done` and the new `exit_req` show up one cycle later, and `done` falls one cycle after that. The bench keeps a behavioural model that steps on the same edges, using only the inputs it drives. It compares every output against that model at each falling edge, so each result is checked in the exact cycle it is due. Directed requests also recompute the decision straight from the bitmap contents and check that it holds for the two following cycles.

// File: rtl/msrbm_pkg.sv
package msrbm_pkg;

    localparam int MAP_OFS_W = 12;

    localparam logic [31:0] LOW_LAST   = 32'h0000_1FFF;
    localparam logic [31:0] HIGH_FIRST = 32'hC000_0000;
    localparam logic [31:0] HIGH_LAST  = 32'hC000_1FFF;

    localparam logic [MAP_OFS_W-1:0] HIGH_HALF_OFS  = MAP_OFS_W'(1024);
    localparam logic [MAP_OFS_W-1:0] WRITE_HALF_OFS = MAP_OFS_W'(2048);

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_FETCH,
        LK_WAIT,
        LK_DONE
    } lk_state_e;

    typedef enum logic [1:0] {
        RG_LOW,
        RG_HIGH,
        RG_NONE
    } msr_region_e;

    typedef struct packed {
        msr_region_e           region;
        logic [MAP_OFS_W-1:0]  byte_ofs;
        logic [2:0]            bit_sel;
    } msr_slot_t;

    // Full range membership: no mask tests on the upper bits.
    function automatic msr_region_e region_of(input logic [31:0] idx);
        if (idx <= LOW_LAST)
            return RG_LOW;
        else if ((idx >= HIGH_FIRST) && (idx <= HIGH_LAST))
            return RG_HIGH;
        return RG_NONE;
    endfunction

    function automatic logic [MAP_OFS_W-1:0] slot_offset(input msr_region_e rg,
                                                         input logic [31:0] idx,
                                                         input logic        is_write);
        logic [31:0]          rel;
        logic [MAP_OFS_W-1:0] ofs;
        rel = (rg == RG_HIGH) ? (idx - HIGH_FIRST) : idx;
        ofs = MAP_OFS_W'(rel >> 3);
        if (rg == RG_HIGH)
            ofs = ofs + HIGH_HALF_OFS;
        if (is_write)
            ofs = ofs + WRITE_HALF_OFS;
        return ofs;
    endfunction

endpackage

// File: rtl/msr_range_decode.sv
module msr_range_decode
    import msrbm_pkg::*;
(
    input  logic [31:0] idx,
    input  logic        is_write,
    output msr_slot_t   slot
);

    msr_region_e rg;

    always_comb begin
        rg            = region_of(idx);
        slot.region   = rg;
        slot.byte_ofs = slot_offset(rg, idx, is_write);
        slot.bit_sel  = idx[2:0];
    end

endmodule

// File: rtl/msr_bit_pick.sv
module msr_bit_pick #(
    parameter int BYTE_W = 8,
    localparam int SEL_W = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_out
);

    logic [BYTE_W-1:0] hit;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign hit[g] = byte_in[g] & (sel == SEL_W'(g));
    end

    assign bit_out = |hit;

endmodule

// File: rtl/msr_lookup_fsm.sv
module msr_lookup_fsm
    import msrbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  msr_slot_t         slot_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic              hit_bit,
    output logic [2:0]        bit_sel_q,
    output logic              busy,
    output logic              done,
    output logic              exit_req,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr
);

    lk_state_e            state;
    logic [MAP_OFS_W-1:0] ofs_q;
    logic [ADDR_W-1:0]    base_q;
    logic                 exit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LK_IDLE;
            ofs_q     <= '0;
            base_q    <= '0;
            bit_sel_q <= '0;
            exit_q    <= 1'b0;
        end else begin
            case (state)
                LK_IDLE: begin
                    if (req_valid) begin
                        ofs_q     <= slot_in.byte_ofs;
                        base_q    <= base_in;
                        bit_sel_q <= slot_in.bit_sel;
                        if (slot_in.region == RG_NONE) begin
                            exit_q <= 1'b1;
                            state  <= LK_DONE;
                        end else begin
                            state  <= LK_FETCH;
                        end
                    end
                end
                LK_FETCH: begin
                    if (mem_req_ready)
                        state <= LK_WAIT;
                end
                LK_WAIT: begin
                    if (mem_rsp_valid) begin
                        exit_q <= hit_bit;
                        state  <= LK_DONE;
                    end
                end
                LK_DONE: state <= LK_IDLE;
                default: state <= LK_IDLE;
            endcase
        end
    end

    assign busy          = (state != LK_IDLE);
    assign done          = (state == LK_DONE);
    assign exit_req      = exit_q;
    assign mem_req_valid = (state == LK_FETCH);
    assign mem_req_addr  = base_q + ADDR_W'(ofs_q);

    // R7: request held with a steady address until accepted
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
        else $error("p_req_hold_r7");

    // R4: a response taken while waiting completes the lookup next cycle
    p_rsp_done_r4: assert property (@(posedge clk) disable iff (rst)
        (state == LK_WAIT && mem_rsp_valid) |=> done)
        else $error("p_rsp_done_r4");

    // R8: single-cycle done pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("p_done_pulse_r8");

    // R8: decision moves only alongside done
    p_exit_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(exit_req))
        else $error("p_exit_hold_r8");

    // R5 / R6: out-of-map index exits next cycle without a fetch
    p_forced_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (state == LK_IDLE && req_valid && slot_in.region == RG_NONE)
            |=> (done && exit_req && !mem_req_valid))
        else $error("p_forced_exit_r5");

    // R9: busy starts only from an offered request
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid))
        else $error("p_busy_start_r9");

endmodule

// File: rtl/msr_intercept_lookup.sv
module msr_intercept_lookup
    import msrbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_index,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] bitmap_base,
    output logic              busy,
    output logic              done,
    output logic              exit_req,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data
);

    msr_slot_t  slot;
    logic [2:0] bit_sel_q;
    logic       hit_bit;

    msr_range_decode u_decode (
        .idx      (req_index),
        .is_write (req_write),
        .slot     (slot)
    );

    msr_bit_pick #(.BYTE_W(8)) u_pick (
        .byte_in (mem_rsp_data),
        .sel     (bit_sel_q),
        .bit_out (hit_bit)
    );

    msr_lookup_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .slot_in       (slot),
        .base_in       (bitmap_base),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .hit_bit       (hit_bit),
        .bit_sel_q     (bit_sel_q),
        .busy          (busy),
        .done          (done),
        .exit_req      (exit_req),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr)
    );

    // R10: quiet outputs right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !exit_req && !mem_req_valid))
        else $error("p_reset_quiet_r10");

endmodule

// File: tb/msr_intercept_lookup_tb_top.sv
`timescale 1ns/1ps
module msr_intercept_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_index = '0;
    logic        req_write = 1'b0;
    logic [31:0] bitmap_base = '0;
    logic        busy, done, exit_req, mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    msr_intercept_lookup #(.ADDR_W(32)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_write(req_write), .bitmap_base(bitmap_base), .busy(busy), .done(done),
        .exit_req(exit_req), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    logic [7:0] bmap [0:4095];
    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;

    // reference model state (advanced on rising edges from driven inputs only)
    int          m_ph = 0;      // 0 idle, 1 requesting, 2 awaiting byte, 3 reporting
    logic        m_exit = 1'b0;
    logic [31:0] m_addr = '0;
    logic [2:0]  m_sel = '0;

    // responder state
    logic [15:0] lf = 16'hACE1;
    logic [31:0] rsp_addr = '0;
    int          lat_cnt = 0;

    function automatic bit in_map(input logic [31:0] idx);
        return (idx < 32'h2000) || (idx >= 32'hC000_0000 && idx < 32'hC000_2000);
    endfunction

    function automatic int map_byte(input logic [31:0] idx, input logic wr);
        int b;
        if (idx < 32'h2000) b = int'(idx / 8);
        else b = 1024 + int'((idx - 32'hC000_0000) / 8);
        if (wr) b = b + 2048;
        return b;
    endfunction

    function automatic logic ref_exit(input logic [31:0] idx, input logic wr);
        int b;
        if (!in_map(idx)) return 1'b1;
        b = map_byte(idx, wr);
        return bmap[b][int'(idx % 8)];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ph   = 0;
            m_exit = 1'b0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    if (!in_map(req_index)) begin
                        m_exit = 1'b1;
                        m_ph   = 3;
                    end else begin
                        m_addr = bitmap_base + 32'(map_byte(req_index, req_write));
                        m_sel  = req_index[2:0];
                        m_ph   = 1;
                    end
                end
                1: if (mem_req_ready) m_ph = 2;
                2: if (mem_rsp_valid) begin
                    m_exit = mem_rsp_data[m_sel];
                    m_ph   = 3;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison, then responder drive
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R9 busy", 32'(busy), 32'(m_ph != 0));
            chk("R8 done", 32'(done), 32'(m_ph == 3));
            chk("R7 mem_req_valid", 32'(mem_req_valid), 32'(m_ph == 1));
            chk("R4 exit_req", 32'(exit_req), 32'(m_exit));
            if (m_ph == 1) chk("R1/R2/R3 address", mem_req_addr, m_addr);
        end
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (m_ph)
            1: begin
                mem_req_ready = stall_mode ? lf[0] : 1'b1;
                mem_rsp_valid = stall_mode & lf[3];
                mem_rsp_data  = 8'hFF;
                if (mem_req_ready) begin
                    rsp_addr = mem_req_addr;
                    lat_cnt  = stall_mode ? int'(lf[5:4]) : 0;
                end
            end
            2: begin
                mem_req_ready = stall_mode & lf[1];
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = bmap[rsp_addr[11:0]];
                end else begin
                    lat_cnt--;
                    mem_rsp_valid = 1'b0;
                    mem_rsp_data  = lf[7:0];
                end
            end
            default: begin
                mem_req_ready = stall_mode & lf[1];
                mem_rsp_valid = stall_mode & lf[2];
                mem_rsp_data  = lf[15:8];
            end
        endcase
    end

    task automatic do_req(input logic [31:0] idx, input logic wr, input logic [31:0] base,
                          input bit intrude, input string tag);
        int   fetches;
        bit   seen;
        logic held;
        while (m_ph != 0) @(negedge clk);
        req_valid   = 1'b1;
        req_index   = idx;
        req_write   = wr;
        bitmap_base = base;
        fetches     = 0;
        seen        = 1'b0;
        while (!seen) begin
            @(negedge clk);
            if (mem_req_valid) fetches++;
            if (done) seen = 1'b1;
            else begin
                req_valid = intrude && (m_ph == 1 || m_ph == 2);
                req_index = idx ^ 32'hC000_0005;
            end
        end
        req_valid = 1'b0;
        chk(tag, 32'(exit_req), 32'(ref_exit(idx, wr)));
        if (!in_map(idx)) chk("R5/R6 no memory read", 32'(fetches), 0);
        else              chk("R7 one fetch issued", 32'(fetches > 0), 1);
        held = exit_req;
        @(negedge clk);
        chk("R8 done single cycle", 32'(done), 0);
        @(negedge clk);
        chk("R8 decision held", 32'(exit_req), 32'(held));
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++)
            bmap[i] = 8'(((i * 73) + ((i >> 4) * 29) + 11) ^ (i >> 2));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 busy after reset", 32'(busy), 0);
        chk("R10 done after reset", 32'(done), 0);
        chk("R10 exit after reset", 32'(exit_req), 0);
        chk("R10 mem_req_valid after reset", 32'(mem_req_valid), 0);

        do_req(32'h0000_0010, 1'b0, 32'h0003_4000, 1'b0, "R1 low read");
        do_req(32'h0000_0000, 1'b0, 32'h0003_4000, 1'b0, "R1 low first");
        do_req(32'h0000_1FFF, 1'b1, 32'h0003_4000, 1'b0, "R3 low write last");
        do_req(32'hC000_0000, 1'b0, 32'hFFFF_F000, 1'b0, "R2 high first");
        do_req(32'hC000_0083, 1'b0, 32'hFFFF_F000, 1'b0, "R2 high read");
        do_req(32'hC000_1FFF, 1'b1, 32'h0003_4000, 1'b0, "R3 high write last");
        do_req(32'h0000_0A37, 1'b1, 32'h0003_4000, 1'b1, "R9 low write with busy intruder");
        do_req(32'hA000_0000, 1'b0, 32'h0003_4000, 1'b0, "R6 mask alias");
        do_req(32'h0000_2000, 1'b1, 32'h0003_4000, 1'b0, "R6 just above low");
        do_req(32'hBFFF_FFFF, 1'b0, 32'h0003_4000, 1'b0, "R6 just below high");
        do_req(32'hC000_2000, 1'b0, 32'h0003_4000, 1'b0, "R5 just above high");
        do_req(32'hFFFF_FFFF, 1'b1, 32'h0003_4000, 1'b1, "R5 top index");

        stall_mode = 1'b1;
        for (int k = 0; k < 80; k++) begin
            logic [31:0] idx;
            logic [31:0] r;
            r = $urandom;
            case (k % 3)
                0: idx = {19'd0, r[12:0]};
                1: idx = 32'hC000_0000 | {19'd0, r[12:0]};
                default: idx = r;
            endcase
            do_req(idx, r[20], (k % 2 == 0) ? 32'h0003_4000 : 32'h8000_0000,
                   r[21], "R4 mixed stalled lookup");
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule